// File: doc/BRIEF.md
# Relocatable Address Map Decoder

This block sits between a 16-bit CPU address bus and the on-chip memories. On every bus cycle it turns the address into a select for one region: internal RAM, the control-register window, EEPROM, a bootstrap ROM, or the external bus. At most one select is active, and a fixed priority settles any overlap between regions.

Two mode pins are captured while reset is held. They set three mode flags: bootstrap ROM present, special mode, and external bus enabled. Software can move RAM and the register window to any 4-Kbyte page through an 8-bit map register. In the normal modes that register takes a single write, and only during a short window after reset; after that it is frozen. The EEPROM page and its enable come from a configuration field supplied as inputs.

Top module: `addr_map_decoder`

## Requirements
- R1: After reset the map register holds 0x01. RAM answers at 0x0000–0x03FF and the register window answers at 0x1000–0x105F. Addresses just beyond either range (0x0400, 0x1060) do not select that region.
- R2: A map write places RAM at page `map_wdata[7:4]` and the register window at page `map_wdata[3:0]`. Here a page is address bits 15:12.
- R3: In the normal modes (single chip, expanded) a write is accepted only while fewer than `WIN` (64) bus cycles have been counted since reset, and only once. A write in the cycle that carries the 64th strobe still counts. Once a write has been taken or the window has closed, `map_locked` is 1 and stays 1, and further writes have no effect on the decode.
- R4: In the special modes (bootstrap, test) map writes are accepted at any time and `map_locked` stays 0. The strobe counter saturates at `WIN` and never wraps.
- R5: When RAM and the register window share a page, the register window wins for the first 96 bytes and RAM answers for the rest of its 1 Kbyte.
- R6: The pins `{mode_b, mode_a}` are captured while `rst_n` is low and map to `{rom_boot, special, ext_bus}` as follows: 10→000 (single chip), 11→001 (expanded), 00→110 (bootstrap), 01→011 (test).
- R7: The bootstrap ROM is selected for 0xBF00–0xBFFF only when `rom_boot` is 1.
- R8: EEPROM responds only when `ee_enable` is 1. With `ext_bus`=1 it covers `{ee_page}`E00–`{ee_page}`FFF. With `ext_bus`=0 it covers 0xFE00–0xFFFF, whatever `ee_page` holds.
- R9: In test mode, addresses `{ee_page}`D00–`{ee_page}`DFF select nothing, external included.
- R10: An address that hits no internal region asserts `sel_ext` only when `ext_bus` is 1. In the single-chip and bootstrap modes it asserts no select.
- R11: Selects are active only while `bus_cyc` is 1, and at most one is active at a time. Priority runs register window, RAM, boot ROM, EEPROM, external.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; mode pins are captured while it is low |
| mode_a | input | 1 | Mode pin A |
| mode_b | input | 1 | Mode pin B |
| bus_cyc | input | 1 | Bus-cycle strobe; qualifies the decode and is counted for the write window |
| addr | input | 16 | CPU address |
| map_wdata | input | 8 | Map register write data: RAM page in 7:4, register page in 3:0 |
| map_we | input | 1 | Map register write enable |
| ee_page | input | 4 | EEPROM page used when the external bus is enabled |
| ee_enable | input | 1 | EEPROM enable |
| sel_reg | output | 1 | Register window select |
| sel_ram | output | 1 | Internal RAM select |
| sel_boot | output | 1 | Bootstrap ROM select |
| sel_eep | output | 1 | EEPROM select |
| sel_ext | output | 1 | External bus select |
| rom_boot | output | 1 | Mode flag: bootstrap ROM present |
| special | output | 1 | Mode flag: special mode |
| ext_bus | output | 1 | Mode flag: external bus enabled |
| map_locked | output | 1 | Map register no longer writable |

## Verification
A wrong map register value appears as misplaced selects on the first strobed address after the faulty write. The decode is combinational, so no delay hides it. A wrong strobe counter or lock bit only shows when a late write is tried: the write is either taken or refused, and `map_locked` is visible one edge after the strobe that closes the window. A wrongly captured mode appears at once on the three mode flags, and on whether boot ROM, EEPROM page and external selects behave as that mode requires.

// File: rtl/addr_map_decoder.sv
module addr_map_decoder #(
  parameter int WIN       = 64,
  parameter int REG_BYTES = 96
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_a,
  input  logic        mode_b,
  input  logic        bus_cyc,
  input  logic [15:0] addr,
  input  logic [7:0]  map_wdata,
  input  logic        map_we,
  input  logic [3:0]  ee_page,
  input  logic        ee_enable,
  output logic        sel_reg,
  output logic        sel_ram,
  output logic        sel_boot,
  output logic        sel_eep,
  output logic        sel_ext,
  output logic        rom_boot,
  output logic        special,
  output logic        ext_bus,
  output logic        map_locked
);
  localparam int CW = $clog2(WIN + 1);
  localparam logic [CW-1:0] CMAX = CW'(WIN);

  logic [7:0]    map_q;
  logic [CW-1:0] cnt_q;
  logic          written_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rom_boot <= ~mode_b & ~mode_a;
      special  <= ~mode_b;
      ext_bus  <= mode_a;
    end
  end

  assign map_locked = ~special & (written_q | (cnt_q == CMAX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_q     <= 8'h01;
      cnt_q     <= '0;
      written_q <= 1'b0;
    end else begin
      if (bus_cyc && cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
      if (map_we && !map_locked) begin
        map_q     <= map_wdata;
        written_q <= 1'b1;
      end
    end
  end

  wire [3:0] page    = addr[15:12];
  wire [3:0] ee_pg   = ext_bus ? ee_page : 4'hF;
  wire hit_reg  = (page == map_q[3:0]) && (addr[11:0] < 12'(REG_BYTES));
  wire hit_ram  = (page == map_q[7:4]) && (addr[11:10] == 2'b00);
  wire hit_boot = rom_boot && (addr[15:8] == 8'hBF);
  wire hit_eep  = ee_enable && (page == ee_pg) && (addr[11:9] == 3'b111);
  wire hole     = special && ext_bus && (page == ee_page) && (addr[11:8] == 4'hD);

  assign sel_reg  = bus_cyc & hit_reg;
  assign sel_ram  = bus_cyc & ~hit_reg & hit_ram;
  assign sel_boot = bus_cyc & ~hit_reg & ~hit_ram & hit_boot;
  assign sel_eep  = bus_cyc & ~hit_reg & ~hit_ram & ~hit_boot & hit_eep;
  assign sel_ext  = bus_cyc & ext_bus & ~hole &
                    ~(hit_reg | hit_ram | hit_boot | hit_eep);

  p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_reg, sel_ram, sel_boot, sel_eep, sel_ext}));
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cyc |-> !(sel_reg | sel_ram | sel_boot | sel_eep | sel_ext));
  p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    map_locked |=> map_locked && $stable(map_q));
  p_special_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    special |-> !map_locked);
  p_cnt_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CMAX);
  p_mode_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable({rom_boot, special, ext_bus}));
  p_boot_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_boot |-> rom_boot);
  p_ext_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ext |-> ext_bus);
endmodule

// File: tb/addr_map_decoder_bench.sv
module addr_map_decoder_bench;
  logic clk = 0, rst_n = 0, mode_a = 0, mode_b = 1, bus_cyc = 0, map_we = 0, ee_enable = 1;
  logic [15:0] addr = '0;
  logic [7:0]  map_wdata = '0;
  logic [3:0]  ee_page = 4'h4;
  logic sel_reg, sel_ram, sel_boot, sel_eep, sel_ext, rom_boot, special, ext_bus, map_locked;
  int errors = 0, checks = 0;

  localparam logic [4:0] NONE = 5'b00000, REG = 5'b10000, RAM = 5'b01000,
                         BOOT = 5'b00100, EEP = 5'b00010, EXT = 5'b00001;

  always #10 clk = ~clk;

  addr_map_decoder u_addr_map_decoder (.*);

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic sel_at(string req, logic [15:0] a, logic [4:0] exp, logic strobe = 1'b1);
    @(negedge clk);
    #1 addr = a; bus_cyc = strobe;
    #2 check(req, 16'({sel_reg, sel_ram, sel_boot, sel_eep, sel_ext}), 16'(exp));
    #1 bus_cyc = 0;
  endtask

  task automatic do_reset(logic b, logic a);
    @(negedge clk); rst_n = 0; mode_b = b; mode_a = a;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic strobes(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) bus_cyc = 1;
      @(posedge clk) #1 bus_cyc = 0;
    end
  endtask

  task automatic map_write(logic [7:0] d);
    @(negedge clk) begin map_we = 1; map_wdata = d; bus_cyc = 1; end
    @(posedge clk) #1 begin map_we = 0; bus_cyc = 0; end
  endtask

  task automatic t_single_chip;
    do_reset(1, 0);
    check("R6 single modes", 16'({rom_boot, special, ext_bus}), 16'b000);
    check("R3 unlocked at reset", 16'(map_locked), 16'd0);
    sel_at("R1 ram low", 16'h0000, RAM);
    sel_at("R1 ram top", 16'h03FF, RAM);
    sel_at("R10 single no ext", 16'h0400, NONE);
    sel_at("R1 reg low", 16'h1000, REG);
    sel_at("R1 reg top", 16'h105F, REG);
    sel_at("R1 reg past", 16'h1060, NONE);
    sel_at("R8 fixed eep", 16'hFE00, EEP);
    sel_at("R8 fixed eep top", 16'hFFFF, EEP);
    sel_at("R8 page ignored", 16'h4E00, NONE);
    sel_at("R7 no boot", 16'hBF00, NONE);
    sel_at("R11 no strobe", 16'h0000, NONE, 1'b0);
    ee_enable = 0;
    sel_at("R8 disabled", 16'hFE00, NONE);
    ee_enable = 1;
  endtask

  task automatic t_remap_once;
    do_reset(1, 0);
    strobes(5);
    map_write(8'h23);
    check("R3 locked after write", 16'(map_locked), 16'd1);
    sel_at("R2 ram moved", 16'h2000, RAM);
    sel_at("R2 ram old", 16'h0000, NONE);
    sel_at("R2 reg moved", 16'h3000, REG);
    sel_at("R2 reg old", 16'h1000, NONE);
    map_write(8'h45);
    sel_at("R3 second write ignored", 16'h2000, RAM);
    sel_at("R3 second write no ram", 16'h4000, NONE);
  endtask

  task automatic t_window_edge;
    do_reset(1, 0);
    strobes(63);
    check("R3 open at 63", 16'(map_locked), 16'd0);
    map_write(8'h41);
    sel_at("R3 last slot accepted", 16'h4000, RAM);
    check("R3 locked", 16'(map_locked), 16'd1);
  endtask

  task automatic t_window_closed;
    do_reset(1, 0);
    strobes(64);
    check("R3 window closed", 16'(map_locked), 16'd1);
    map_write(8'h51);
    sel_at("R3 late write ignored", 16'h5000, NONE);
    sel_at("R3 ram stays", 16'h0000, RAM);
  endtask

  task automatic t_expanded_overlap;
    do_reset(1, 1);
    check("R6 expanded modes", 16'({rom_boot, special, ext_bus}), 16'b001);
    map_write(8'h77);
    sel_at("R5 reg wins low", 16'h7000, REG);
    sel_at("R5 reg wins top", 16'h705F, REG);
    sel_at("R5 ram after", 16'h7060, RAM);
    sel_at("R5 ram top", 16'h73FF, RAM);
    sel_at("R10 expanded ext", 16'h7400, EXT);
    sel_at("R8 paged eep", 16'h4E00, EEP);
    sel_at("R8 fixed page gone", 16'hFE00, EXT);
    sel_at("R9 no hole outside test", 16'h4D00, EXT);
  endtask

  task automatic t_bootstrap;
    do_reset(0, 0);
    check("R6 boot modes", 16'({rom_boot, special, ext_bus}), 16'b110);
    sel_at("R7 boot low", 16'hBF00, BOOT);
    sel_at("R7 boot top", 16'hBFFF, BOOT);
    sel_at("R7 below boot", 16'hBEFF, NONE);
    sel_at("R10 boot no ext", 16'h8000, NONE);
    strobes(80);
    check("R4 never locked", 16'(map_locked), 16'd0);
    map_write(8'hB0);
    map_write(8'hB0);
    sel_at("R4 late write reg", 16'h0000, REG);
    sel_at("R4 late write ram", 16'hB000, RAM);
    map_write(8'hBB);
    sel_at("R11 reg over ram", 16'hB000, REG);
    sel_at("R11 ram over boot", 16'hB100, RAM);
  endtask

  task automatic t_test_mode;
    do_reset(0, 1);
    check("R6 test modes", 16'({rom_boot, special, ext_bus}), 16'b011);
    sel_at("R8 test eep", 16'h4E00, EEP);
    sel_at("R8 test eep top", 16'h4FFF, EEP);
    sel_at("R9 hole low", 16'h4D00, NONE);
    sel_at("R9 hole top", 16'h4DFF, NONE);
    sel_at("R10 test ext", 16'h4C00, EXT);
    ee_enable = 0;
    sel_at("R8 test disabled", 16'h4E00, EXT);
    ee_enable = 1;
    strobes(70);
    map_write(8'hF4);
    check("R4 test unlocked", 16'(map_locked), 16'd0);
    sel_at("R11 reg over eep page", 16'h4000, REG);
    sel_at("R11 ram high", 16'hF000, RAM);
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_single_chip();
    t_remap_once();
    t_window_edge();
    t_window_closed();
    t_expanded_overlap();
    t_bootstrap();
    t_test_mode();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule